// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block is the host side of a parallel successive-approximation converter with an 8-bit data bus. A request names a channel, an input range, a power field, an acquisition style and an acquisition length. The block turns it into chip-select and write strobes that carry a control byte. It waits for the converter's active-low completion flag. It then reads the two halves of the 12-bit result with the byte-select line low and then high, and returns the merged word with a one-cycle valid pulse.

There are two acquisition styles. With internal acquisition, one write starts conversion. With external acquisition, two writes are sent: the first starts tracking, and the second ends it and starts conversion after a programmable pause. A request marked as power-down sends a single write and does nothing more. If the completion flag does not fall within a set number of cycles, the block reports a timeout instead of reading.

Top module: `adc_bus_master`

## Requirements
- R1: The control byte carries the channel in bits 2:0, the range code in bits 4:3, the external-acquisition flag in bit 5 and the power field in bits 7:6. `adc_dout` is zero whenever `adc_oe` is low.
- R2: After a request is accepted, `adc_cs_n` and `adc_wr_n` are low for exactly STROBE_CYC cycles, starting the cycle after acceptance. The control byte holds steady on `adc_dout` for that whole window.
- R3: With external acquisition, the first write has bit 5 set. It is followed by max(acq_len,1) cycles with all strobes high, then a second write of STROBE_CYC cycles with the same byte but bit 5 cleared.
- R4: After the conversion write, the block samples `adc_int_n` every cycle. The cycle after it is seen low, a read (`adc_cs_n`, `adc_rd_n` low, `adc_hben` low) lasts STROBE_CYC cycles. One cycle with strobes high and `adc_hben` high follows, then a second read of STROBE_CYC cycles with `adc_hben` high.
- R5: The result is {second read bits 3:0, first read bits 7:0}; bits 7:4 of the second read are ignored. `rsp_valid` pulses for one cycle right after the second read, with `rsp_timeout` low. `rsp_data` and `rsp_timeout` hold until the next accepted request, which clears them to zero.
- R6: If `adc_int_n` stays high for TIMEOUT_CYC consecutive wait cycles, no read is made. `rsp_valid` pulses the next cycle with `rsp_timeout` high and `rsp_data` zero.
- R7: A power-down request sends one write with bit 5 forced to 0 (whatever the acquisition flag says). No wait or read follows and no `rsp_valid` is produced. `busy` falls the cycle after the strobe ends.
- R8: `adc_oe` is high exactly while `adc_wr_n` is low, and never while `adc_rd_n` is low. `adc_wr_n` and `adc_rd_n` are never low together.
- R9: `busy` is high from the cycle after acceptance through the response cycle. Requests presented while `busy` is high are ignored.
- R10: During reset, all strobes are high, `adc_oe`, `busy` and `rsp_valid` are low, and `rsp_data` and `rsp_timeout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_chan | input | 3 | Channel number |
| req_range | input | 2 | Range code |
| req_ext_acq | input | 1 | Externally timed acquisition |
| req_pwr_down | input | 1 | Send the control byte only, no conversion |
| req_pwr_mode | input | 2 | Power field of the control byte |
| req_acq_len | input | ACQ_W | Pause between the two writes, in clocks |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 12 | Assembled result |
| rsp_timeout | output | 1 | Completion flag did not arrive |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hben | output | 1 | High-nibble select for reads |
| adc_int_n | input | 1 | Conversion complete, active low |
| adc_dout | output | 8 | Control byte toward the bus |
| adc_oe | output | 1 | Host bus drive enable |
| adc_din | input | 8 | Data read from the bus |

## Verification
The bench builds the block with STROBE_CYC = 3 and TIMEOUT_CYC = 40 so that every strobe window, the timeout and a flag arriving in the very last allowed wait cycle all fit in short runs. The 8-bit acquisition length lets it try a zero pause, which must behave as one cycle, next to an ordinary pause. A converter stand-in returns junk in the upper nibble of the high read, and requests are held high during busy periods to show they are ignored.

// File: rtl/adc_bm_pkg.sv
`timescale 1ns/1ps
package adc_bm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WR1, S_GAP, S_WR2, S_WAIT, S_RDL, S_RDG, S_RDH, S_RESP
  } seq_state_t;

  // Control byte: power field, acquisition flag, range, channel
  function automatic logic [7:0] pack_ctrl(input logic [1:0] pwr, input logic ext,
                                           input logic [1:0] rng, input logic [2:0] ch);
    return {pwr, ext, rng, ch};
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
`timescale 1ns/1ps
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/adc_cycle_ctr.sv
`timescale 1ns/1ps
module adc_cycle_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
  import adc_bm_pkg::*;
#(
  parameter int STROBE_CYC  = 20,
  parameter int TIMEOUT_CYC = 1000,
  parameter int ACQ_W       = 8,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             ext_q,
  input  logic             pd_q,
  input  logic [ACQ_W-1:0] acq_q,
  input  logic             int_n,
  input  logic [CNT_W-1:0] cnt,
  output seq_state_t       st,
  output logic             ctr_clr,
  output logic             accept,
  output logic             cap_lo,
  output logic             cap_hi,
  output logic             tmo
);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_t nxt;
  logic last_stb, gap_done;

  assign last_stb = (cnt == STB_LAST);
  assign gap_done = ((cnt + 1'b1) >= CNT_W'(acq_q));

  always_comb begin
    nxt     = st;
    ctr_clr = 1'b0;
    accept  = 1'b0;
    cap_lo  = 1'b0;
    cap_hi  = 1'b0;
    tmo     = 1'b0;
    unique case (st)
      S_IDLE: begin
        ctr_clr = 1'b1;
        if (req_valid) begin accept = 1'b1; nxt = S_WR1; end
      end
      S_WR1: if (last_stb) begin
        ctr_clr = 1'b1;
        if (pd_q)       nxt = S_IDLE;
        else if (ext_q) nxt = S_GAP;
        else            nxt = S_WAIT;
      end
      S_GAP: if (gap_done) begin ctr_clr = 1'b1; nxt = S_WR2; end
      S_WR2: if (last_stb) begin ctr_clr = 1'b1; nxt = S_WAIT; end
      S_WAIT: begin
        if (!int_n) begin
          ctr_clr = 1'b1; nxt = S_RDL;
        end else if (cnt == TMO_LAST) begin
          ctr_clr = 1'b1; tmo = 1'b1; nxt = S_RESP;
        end
      end
      S_RDL: if (last_stb) begin ctr_clr = 1'b1; cap_lo = 1'b1; nxt = S_RDG; end
      S_RDG: begin ctr_clr = 1'b1; nxt = S_RDH; end
      S_RDH: if (last_stb) begin ctr_clr = 1'b1; cap_hi = 1'b1; nxt = S_RESP; end
      S_RESP: begin ctr_clr = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/adc_result_asm.sv
`timescale 1ns/1ps
module adc_result_asm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap_lo,
  input  logic        cap_hi,
  input  logic        set_err,
  input  logic [7:0]  din,
  output logic [11:0] data,
  output logic        err
);
  logic [7:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      data <= '0;
      err  <= 1'b0;
    end else begin
      if (cap_lo) lo_q <= din;
      if (clr) begin
        data <= '0;
        err  <= 1'b0;
      end else begin
        if (cap_hi)  data <= {din[3:0], lo_q};
        if (set_err) err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_bus_master.sv
`timescale 1ns/1ps
module adc_bus_master
  import adc_bm_pkg::*;
#(
  parameter int STROBE_CYC  = 20,
  parameter int TIMEOUT_CYC = 1000,
  parameter int ACQ_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_chan,
  input  logic [1:0]       req_range,
  input  logic             req_ext_acq,
  input  logic             req_pwr_down,
  input  logic [1:0]       req_pwr_mode,
  input  logic [ACQ_W-1:0] req_acq_len,
  output logic             busy,
  output logic             rsp_valid,
  output logic [11:0]      rsp_data,
  output logic             rsp_timeout,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic             adc_hben,
  input  logic             adc_int_n,
  output logic [7:0]       adc_dout,
  output logic             adc_oe,
  input  logic [7:0]       adc_din
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int STB_W = $clog2(STROBE_CYC + 1);
  localparam int MAX_W = (TMO_W > STB_W) ? TMO_W : STB_W;
  localparam int CNT_W = ((MAX_W > ACQ_W) ? MAX_W : ACQ_W) + 1;

  logic             rst_s_n;
  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             ctr_clr, accept, cap_lo, cap_hi, tmo;
  logic [2:0]       chan_q;
  logic [1:0]       rng_q, pwr_q;
  logic             ext_q, pd_q, ext_eff;
  logic [ACQ_W-1:0] acq_q;
  logic [7:0]       ctrl_byte;
  logic             in_wr, in_rd;

  adc_rst_sync u_rst_sync (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s_n));

  // Request register, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      chan_q <= '0; rng_q <= '0; pwr_q <= '0;
      ext_q  <= 1'b0; pd_q <= 1'b0; acq_q <= '0;
    end else if (accept) begin
      chan_q <= req_chan;     rng_q <= req_range;  pwr_q <= req_pwr_mode;
      ext_q  <= req_ext_acq;  pd_q  <= req_pwr_down; acq_q <= req_acq_len;
    end
  end

  assign ext_eff = ext_q & ~pd_q;

  adc_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_s_n), .clr(ctr_clr), .en(busy), .cnt(cnt)
  );

  adc_seq_fsm #(
    .STROBE_CYC(STROBE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .ACQ_W(ACQ_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .req_valid(req_valid), .ext_q(ext_eff), .pd_q(pd_q),
    .acq_q(acq_q), .int_n(adc_int_n), .cnt(cnt), .st(st), .ctr_clr(ctr_clr),
    .accept(accept), .cap_lo(cap_lo), .cap_hi(cap_hi), .tmo(tmo)
  );

  adc_result_asm u_res (
    .clk(clk), .rst_n(rst_s_n), .clr(accept), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .set_err(tmo), .din(adc_din), .data(rsp_data), .err(rsp_timeout)
  );

  // Bus decode from the sequencer state
  assign in_wr     = (st == S_WR1) || (st == S_WR2);
  assign in_rd     = (st == S_RDL) || (st == S_RDH);
  assign adc_cs_n  = !(in_wr || in_rd);
  assign adc_wr_n  = !in_wr;
  assign adc_rd_n  = !in_rd;
  assign adc_hben  = (st == S_RDG) || (st == S_RDH);
  assign adc_oe    = in_wr;
  assign busy      = (st != S_IDLE);
  assign rsp_valid = (st == S_RESP);

  // Second external write clears the acquisition flag
  assign ctrl_byte = pack_ctrl(pwr_q, ext_eff && (st == S_WR1), rng_q, chan_q);
  assign adc_dout  = adc_oe ? ctrl_byte : 8'h00;

  // R8
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(!adc_wr_n && !adc_rd_n));
  // R8
  oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !adc_rd_n |-> !adc_oe);
  // R2
  wr_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !adc_wr_n |-> !adc_cs_n);
  // R2
  dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!adc_wr_n && $past(!adc_wr_n)) |-> $stable(adc_dout));
  // R5
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |=> !rsp_valid);
  // R1
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(adc_oe) |-> (adc_dout == 8'h00));
endmodule

// File: tb/adc_bus_master_bench.sv
`timescale 1ns/1ps
module adc_bus_master_bench;
  localparam int STB = 3;
  localparam int TO  = 40;
  localparam int AW  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, req_valid, req_ext_acq, req_pwr_down, adc_int_n;
  logic [2:0]    req_chan;
  logic [1:0]    req_range, req_pwr_mode;
  logic [AW-1:0] req_acq_len;
  logic          busy, rsp_valid, rsp_timeout, adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_oe;
  logic [11:0]   rsp_data;
  logic [7:0]    adc_dout, adc_din, drv_lo;
  logic [3:0]    drv_hi;

  // Converter stand-in: junk in the upper nibble of the high read
  assign adc_din = adc_hben ? {4'h5, drv_hi} : drv_lo;

  adc_bus_master #(.STROBE_CYC(STB), .TIMEOUT_CYC(TO), .ACQ_W(AW)) u_adc_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_range(req_range), .req_ext_acq(req_ext_acq), .req_pwr_down(req_pwr_down),
    .req_pwr_mode(req_pwr_mode), .req_acq_len(req_acq_len), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_hben(adc_hben),
    .adc_int_n(adc_int_n), .adc_dout(adc_dout), .adc_oe(adc_oe), .adc_din(adc_din)
  );

  typedef struct packed {
    logic rv; logic [2:0] ch; logic [1:0] rg; logic ext; logic pd; logic [1:0] pw;
    logic [7:0] acq; logic intn; logic [7:0] dlo; logic [3:0] dhi;
    logic busy, csn, wrn, rdn, hb, oe; logic [7:0] dout;
    logic vld, err; logic [11:0] data;
  } ent_t;

  ent_t        q[$];
  logic [11:0] m_data;
  logic        m_err;
  int          checks = 0;
  int          errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic ent_t idle_e();
    ent_t e;
    e = '0;
    e.intn = 1'b1; e.csn = 1'b1; e.wrn = 1'b1; e.rdn = 1'b1;
    e.data = m_data; e.err = m_err;
    return e;
  endfunction

  task automatic push_n(input ent_t e, input int n);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  // Expected timeline of one request; dly < 0 means the flag never falls
  task automatic add_req(input logic [2:0] ch, input logic [1:0] rg, input logic ext,
                         input logic pd, input logic [1:0] pw, input logic [7:0] acq,
                         input int dly, input logic [7:0] lo, input logic [3:0] hi,
                         input logic junk);
    ent_t e, b;
    logic [7:0] byte1;
    e = idle_e();
    e.rv = 1'b1; e.ch = ch; e.rg = rg; e.ext = ext; e.pd = pd; e.pw = pw; e.acq = acq;
    q.push_back(e);
    m_data = '0; m_err = 1'b0;
    byte1 = {pw, ext & ~pd, rg, ch};
    b = idle_e(); b.busy = 1'b1; b.dlo = lo; b.dhi = hi;
    if (junk) begin
      b.rv = 1'b1; b.ch = ~ch; b.rg = ~rg; b.ext = ~ext; b.pw = ~pw; b.acq = 8'hFF;
    end
    e = b; e.csn = 1'b0; e.wrn = 1'b0; e.oe = 1'b1; e.dout = byte1;
    push_n(e, STB);
    if (pd) return;
    if (ext) begin
      push_n(b, (acq == 0) ? 1 : int'(acq));
      e.dout = byte1 & 8'hDF;
      push_n(e, STB);
    end
    if (dly >= 0 && dly < TO) begin
      push_n(b, dly);
      e = b; e.intn = 1'b0; q.push_back(e);
      e = b; e.csn = 1'b0; e.rdn = 1'b0; push_n(e, STB);
      e = b; e.hb = 1'b1; q.push_back(e);
      e.csn = 1'b0; e.rdn = 1'b0; push_n(e, STB);
      m_data = {hi, lo};
    end else begin
      push_n(b, TO);
      m_err = 1'b1;
    end
    e = b; e.vld = 1'b1; e.data = m_data; e.err = m_err;
    q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ent_t e;
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_range = '0; req_ext_acq = 1'b0;
    req_pwr_down = 1'b0; req_pwr_mode = '0; req_acq_len = '0; adc_int_n = 1'b1;
    drv_lo = '0; drv_hi = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 busy", busy, 0);       chk("R10 cs_n", adc_cs_n, 1);
      chk("R10 wr_n", adc_wr_n, 1);   chk("R10 rd_n", adc_rd_n, 1);
      chk("R10 oe", adc_oe, 0);       chk("R10 rsp_valid", rsp_valid, 0);
      chk("R10 rsp_data", rsp_data, 0); chk("R10 rsp_timeout", rsp_timeout, 0);
    end
    rst_n = 1'b1;
    m_data = '0; m_err = 1'b0;
    push_n(idle_e(), 4);
    // R4 R5: internal acquisition, flag after 4 wait cycles
    add_req(3'd5, 2'd2, 1'b0, 1'b0, 2'd0, 8'd0, 4, 8'hA5, 4'hC, 1'b0);
    push_n(idle_e(), 3);
    // R3 R9: external acquisition, pause 5, flag at once, requests while busy
    add_req(3'd3, 2'd1, 1'b1, 1'b0, 2'd1, 8'd5, 0, 8'h3C, 4'h7, 1'b1);
    push_n(idle_e(), 2);
    // R3 R6: zero pause acts as one cycle, flag in the last allowed wait cycle
    add_req(3'd7, 2'd3, 1'b1, 1'b0, 2'd2, 8'd0, TO - 1, 8'h01, 4'h8, 1'b0);
    push_n(idle_e(), 2);
    // R6: flag never falls
    add_req(3'd1, 2'd0, 1'b0, 1'b0, 2'd0, 8'd0, -1, 8'h00, 4'h0, 1'b1);
    push_n(idle_e(), 3);
    // R7: power-down, acquisition flag forced off
    add_req(3'd2, 2'd1, 1'b1, 1'b1, 2'd3, 8'd9, 0, 8'h00, 4'h0, 1'b0);
    push_n(idle_e(), 3);
    // R1 R5: back-to-back requests, all-ones data with junk nibble
    add_req(3'd6, 2'd2, 1'b0, 1'b0, 2'd1, 8'd0, 2, 8'hFF, 4'hF, 1'b0);
    add_req(3'd0, 2'd0, 1'b0, 1'b0, 2'd0, 8'd0, 1, 8'h5A, 4'h2, 1'b1);
    push_n(idle_e(), 4);

    while (q.size() > 0) begin
      @(negedge clk);
      e = q.pop_front();
      req_valid = e.rv; req_chan = e.ch; req_range = e.rg; req_ext_acq = e.ext;
      req_pwr_down = e.pd; req_pwr_mode = e.pw; req_acq_len = e.acq;
      adc_int_n = e.intn; drv_lo = e.dlo; drv_hi = e.dhi;
      chk("R9 busy", busy, e.busy);
      chk("R2 cs_n", adc_cs_n, e.csn);
      chk("R2 wr_n", adc_wr_n, e.wrn);
      chk("R4 rd_n", adc_rd_n, e.rdn);
      chk("R4 hben", adc_hben, e.hb);
      chk("R8 oe", adc_oe, e.oe);
      chk("R1 dout", adc_dout, e.dout);
      chk("R5 rsp_valid", rsp_valid, e.vld);
      chk("R6 rsp_timeout", rsp_timeout, e.err);
      chk("R5 rsp_data", rsp_data, e.data);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule